// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous up-counter built from a chain of 4-bit stages. Every stage is clocked on the rising edge of one shared clock, so all count bits change together. The default configuration chains two stages into an 8-bit counter. A single top-level interface drives the chain, and the chain's combined carry is the terminal-count signal for a further chain.

Each stage has a register, an operation decoder and a carry term. A stage advances only when the shared P enable is high and its own T input is high. The first stage's T input is the external T pin. Every later stage takes its T input from the carry of the stage below it, so a higher stage steps only when every lower stage holds all ones.

The parallel load is synchronous, active-low and reaches every stage. It overrides both enables. The clear is asynchronous and active-low, and it overrides everything else. The counter has no streaming data path, so all pins are plain control and data levels with no valid/ready handshake and no back-pressure.

Top module: `cascade_counter`

## Requirements
- R1: While `clr_n` is low, `count` is 0 at once, without waiting for a clock edge.
- R2: With `clr_n` high and `ld_n` low, a rising edge copies `load_data` into `count`, whatever the levels of `en_p` and `en_t`.
- R3: With `clr_n` and `ld_n` high and both `en_p` and `en_t` high, a rising edge adds 1 to `count`.
- R4: With `clr_n` and `ld_n` high and either `en_p` or `en_t` low, a rising edge leaves `count` unchanged.
- R5: `carry_out` is 1 exactly when `en_t` is 1 and every bit of `count` is 1 (value 255 in the default 8-bit configuration). Otherwise it is 0.
- R6: `carry_out` is combinational. Lowering `en_t` drops it in the same cycle, with no clock edge.
- R7: Counting from the all-ones value gives 0 on the next edge. No other overflow signal exists.
- R8: The upper 4-bit stage, `count[7:4]`, changes on a count edge only when the lower stage, `count[3:0]`, is 15.
- R9: If `clr_n` and `ld_n` are both low at an edge, `count` is 0. Clear has priority over load, load over count, and count over hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clr_n | input | 1 | Asynchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| load_data | input | STAGE_W*NUM_STAGES | Value that a load copies into the counter |
| en_p | input | 1 | Count enable sent to every stage |
| en_t | input | 1 | Count enable for the first stage; also gates the carry |
| count | output | STAGE_W*NUM_STAGES | Current count |
| carry_out | output | 1 | High when `en_t` is high and the count is all ones |

## Verification
The bench loads every 8-bit value with each combination of enables. A design that let the enables gate the load would keep the old count here instead of the loaded one. Counting runs through the nibble boundaries and the 255-to-0 wrap. A broken carry chain would step the upper nibble too early, or stall it at 0x0F and 0xFF. The carry is sampled between clock edges. One test drops `en_t` in the middle of a cycle and checks that a registered carry, which would stay high for a full cycle, cannot pass. The clear is also driven together with load, and between edges. An edge-triggered clear or a clear that lost to load would show the loaded value where 0 is expected.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } stage_op_e;
endpackage

// File: rtl/cnt_stage_ctl.sv
`timescale 1ns/1ps
module cnt_stage_ctl
  import cnt_pkg::*;
(
  input  logic      ld_n,
  input  logic      en_p,
  input  logic      en_t,
  output stage_op_e op
);
  // Load wins over counting; counting needs both enables.
  always_comb begin
    if (!ld_n)              op = OP_LOAD;
    else if (en_p && en_t)  op = OP_COUNT;
    else                    op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
`timescale 1ns/1ps
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rco
);
  stage_op_e op;

  cnt_stage_ctl u_ctl (
    .ld_n (ld_n),
    .en_p (en_p),
    .en_t (en_t),
    .op   (op)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      case (op)
        OP_LOAD:  q <= d;
        OP_COUNT: q <= q + 1'b1;
        default:  q <= q;
      endcase
    end
  end

  // Terminal count, gated by T only, so stages chain without extra logic.
  assign rco = en_t & (&q);
endmodule

// File: rtl/cascade_counter.sv
`timescale 1ns/1ps
module cascade_counter #(
  parameter int STAGE_W    = 4,
  parameter int NUM_STAGES = 2,
  localparam int TOT_W     = STAGE_W * NUM_STAGES
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic [TOT_W-1:0] load_data,
  input  logic             en_p,
  input  logic             en_t,
  output logic [TOT_W-1:0] count,
  output logic             carry_out
);
  logic [NUM_STAGES:0] t_chain;

  assign t_chain[0] = en_t;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk   (clk),
      .clr_n (clr_n),
      .ld_n  (ld_n),
      .en_p  (en_p),
      .en_t  (t_chain[i]),
      .d     (load_data[i*STAGE_W +: STAGE_W]),
      .q     (count[i*STAGE_W +: STAGE_W]),
      .rco   (t_chain[i+1])
    );
  end

  assign carry_out = t_chain[NUM_STAGES];
endmodule

// File: rtl/cascade_counter_chk.sv
`timescale 1ns/1ps
module cascade_counter_chk #(
  parameter int STAGE_W    = 4,
  parameter int NUM_STAGES = 2,
  localparam int TOT_W     = STAGE_W * NUM_STAGES
) (
  input logic             clk,
  input logic             clr_n,
  input logic             ld_n,
  input logic [TOT_W-1:0] load_data,
  input logic             en_p,
  input logic             en_t,
  input logic [TOT_W-1:0] count,
  input logic             carry_out
);
  // R1 and R9: clear forces zero regardless of load
  assert_clear_zero_R1: assert property (@(posedge clk)
    !clr_n |-> (count == '0));

  assert_load_copies_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> (count == $past(load_data)));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_p && en_t) |=> (count == TOT_W'($past(count) + 1'b1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_p && en_t)) |=> $stable(count));

  assert_carry_term_R5: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out == (en_t && (count == {TOT_W{1'b1}})));

  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_p && en_t && count == {TOT_W{1'b1}}) |=> (count == '0));

  if (NUM_STAGES > 1) begin : g_cascade
    assert_upper_waits_R8: assert property (@(posedge clk) disable iff (!clr_n)
      (ld_n && count[STAGE_W-1:0] != {STAGE_W{1'b1}})
        |=> (count[TOT_W-1:STAGE_W] == $past(count[TOT_W-1:STAGE_W])));
  end
endmodule

bind cascade_counter cascade_counter_chk #(
  .STAGE_W    (STAGE_W),
  .NUM_STAGES (NUM_STAGES)
) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .ld_n      (ld_n),
  .load_data (load_data),
  .en_p      (en_p),
  .en_t      (en_t),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/sim_cascade_counter.sv
`timescale 1ns/1ps
module sim_cascade_counter;
  logic       clk = 1'b0;
  logic       clr_n, ld_n, en_p, en_t;
  logic [7:0] load_data;
  logic [7:0] count;
  logic       carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  int m        = 0;        // bench model of the count
  string next_tag = "R1";

  always #4 clk = ~clk;    // 125 MHz

  cascade_counter #(.STAGE_W(4), .NUM_STAGES(2)) u0 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .load_data(load_data),
    .en_p(en_p), .en_t(en_t), .count(count), .carry_out(carry_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock cycle: check the previous result, apply inputs, check the
  // carry between edges, then advance the model at the rising edge.
  task automatic cyc(input bit cl, input bit ld, input bit p, input bit t,
                     input int d);
    @(negedge clk);
    chk(next_tag, int'(count), m);
    clr_n = cl; ld_n = ld; en_p = p; en_t = t; load_data = d[7:0];
    #1;
    if (!cl) begin
      chk("R1", int'(count), 0);
      m = 0;
    end
    chk("R5", int'(carry_out), int'(t && m == 255));
    @(posedge clk);
    if (!cl) begin
      next_tag = ld ? "R1" : "R9";
      m = 0;
    end else if (!ld) begin
      next_tag = "R2";
      m = d & 255;
    end else if (p && t) begin
      if (m == 255)            next_tag = "R7";
      else if ((m & 15) == 15) next_tag = "R8";
      else                     next_tag = "R3";
      m = (m + 1) & 255;
    end else begin
      next_tag = "R4";
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    clr_n = 1'b0; ld_n = 1'b1; en_p = 1'b1; en_t = 1'b1; load_data = 8'h00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(count), 0);
    chk("R5", int'(carry_out), 0);

    // every load value under every enable combination (R2)
    for (int v = 0; v < 256; v++)
      for (int e = 0; e < 4; e++)
        cyc(1, 0, e[0], e[1], v);

    // clear with load asserted, taken between edges (R9, R1)
    cyc(1, 0, 0, 0, 255);
    cyc(0, 0, 1, 1, 170);
    cyc(1, 1, 0, 0, 0);

    // preset 12, then count through two full wraps (R3, R7, R8)
    cyc(1, 0, 0, 0, 12);
    for (int i = 0; i < 520; i++) cyc(1, 1, 1, 1, 0);

    // hold patterns at several values (R4)
    for (int v = 0; v < 256; v += 17) begin
      cyc(1, 0, 1, 1, v);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 1, 1, 0, 0);
      cyc(1, 1, 0, 1, 0);
    end

    // boundary of the lower nibble (R8): 0x3E -> 0x3F -> 0x40
    cyc(1, 0, 0, 0, 8'h3E);
    cyc(1, 1, 1, 1, 0);
    cyc(1, 1, 1, 1, 0);
    cyc(1, 1, 0, 0, 0);
    @(negedge clk);
    chk("R8", int'(count), 8'h40);

    // carry drops with T inside one cycle (R6)
    cyc(1, 0, 0, 0, 255);
    @(negedge clk);
    chk(next_tag, int'(count), m);
    en_t = 1'b1; en_p = 1'b0; ld_n = 1'b1;
    #1 chk("R6", int'(carry_out), 1);
    en_t = 1'b0;
    #1 chk("R6", int'(carry_out), 0);
    @(posedge clk);
    next_tag = "R4";

    // random mix of all controls
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom;
      cyc((r & 63) != 0, (r & 48) != 0 ? 1'b1 : 1'b0, r[8] | r[9], r[10] | r[11],
          (r >> 16) & 255);
    end
    @(negedge clk);
    chk(next_tag, int'(count), m);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule